// File: doc/BRIEF.md
# Pseudo-Random Sequence Lock Monitor

This block watches the sample streams of several converter channels while the converters send a known pseudo-random test sequence, and tells whether each data link is carrying that sequence correctly. Each channel has its own expected-value generator. While the channel is out of lock, the generator keeps loading itself from the received data, so it can lock onto a stream that starts at any point. Once locked, it runs on its own and predicts every following word.

Lock is decided with asymmetric hysteresis. A short run of good words brings a channel into lock, and a much longer run of bad words takes it out again. A second, sticky error flag catches isolated bad words, but only while the channel is locked. Software clears each flag by pulsing its clear input. Two outputs OR the per-channel flags together, which gives one combined status for the whole set of channels.

Top module: `pn_sync_monitor`

## Requirements
- R1: After reset, every channel has its out-of-lock flag `oos_o` at 1 and its error flag `err_o` at 0.
- R2: The two select bits of each channel pick the sequence. Code 0 selects x^9+x^5+1. Code 1 selects x^23+x^18+1. Code 2 selects the same 23-order sequence with every data bit inverted. Code 3 selects x^7+x^6+1. Bit DW-1 of a word is its earliest sequence bit. The sequence advances by one word per valid sample. While out of lock, the generator reloads its history from each received word.
- R3: While out of lock, the clock edge that takes the 16th matching valid word in a row clears `oos_o`. A mismatching word restarts that run.
- R4: While in lock, the clock edge that takes the 64th mismatching valid word in a row sets `oos_o`. A matching word restarts that run.
- R5: While in lock, a mismatching valid word sets `err_o`. The flag then stays set through any later matching words.
- R6: `err_o` is never 1 while `oos_o` is 1. It is cleared on the edge where lock is lost, and mismatches seen while out of lock never set it.
- R7: A pulse on `err_clr_i` clears `err_o` on the next edge. If a mismatch arrives on the same edge, the mismatch wins and the flag stays set.
- R8: A pulse on `oos_clr_i` while out of lock forces the channel into lock on the next edge. The generator then runs on from the history it has received. While in lock, the pulse has no effect: neither flag changes and the current mismatch run is kept.
- R9: A cycle with no valid word and no clear pulse leaves both flags of that channel unchanged.
- R10: `any_oos_o` and `any_err_o` are the OR of the channel flags, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | NCH | Per-channel sample strobe |
| data_i | input | NCH*DW | Channel samples, channel c in bits [c*DW +: DW] |
| sel_i | input | 2*NCH | Per-channel sequence select, channel c in bits [2c +: 2] |
| oos_clr_i | input | NCH | Per-channel clear pulse for the out-of-lock flag |
| err_clr_i | input | NCH | Per-channel clear pulse for the error flag |
| oos_o | output | NCH | Per-channel out-of-lock flag |
| err_o | output | NCH | Per-channel sticky error flag |
| any_oos_o | output | 1 | OR of all out-of-lock flags |
| any_err_o | output | 1 | OR of all error flags |

## Verification
The hardest state to reach is a loss of lock. It needs 64 bad words in a row while the channel is locked, and the generator must stay aligned with the bench stream the whole time. Otherwise a self-loading generator could absorb the damage. The bench keeps its own copy of each sequence and damages only the newest bit of a word. The generator therefore never takes the bad word into its history while in lock, and every damaged word counts as exactly one mismatch. A clear pulse in the middle of that run checks that the run is kept. While out of lock, the first good word after a damaged one is predicted to fail, because the reloaded history carries the damage. The bench models this explicitly. The seeds are chosen so the zero history left by reset agrees with the stream, which makes the cycle of lock acquisition exact for every sequence.

// File: rtl/pn_mon_pkg.sv
package pn_mon_pkg;

  typedef enum logic [1:0] {
    PN_SEL_9      = 2'd0,
    PN_SEL_23     = 2'd1,
    PN_SEL_23_INV = 2'd2,
    PN_SEL_7      = 2'd3
  } pn_sel_e;

  localparam int PN_MAX_ORDER = 23;
  localparam int PN_SEL_W     = $bits(pn_sel_e);

  function automatic logic pn_inverted(pn_sel_e s);
    return s == PN_SEL_23_INV;
  endfunction

endpackage

// File: rtl/pn_gen.sv
module pn_gen
  import pn_mon_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          reseed_i,
  input  pn_sel_e       sel_i,
  input  logic [DW-1:0] sample_i,
  output logic [DW-1:0] expect_o
);

  localparam int HW = (DW > PN_MAX_ORDER) ? DW : PN_MAX_ORDER;

  logic [HW-1:0] hist_q, hist_adv, hist_load;
  logic [DW-1:0] inv_mask;

  assign inv_mask = {DW{pn_inverted(sel_i)}};

  // advance the serial sequence DW steps; newest bit lands at index 0
  always_comb begin
    logic [HW-1:0] h;
    logic fb;
    h = hist_q;
    for (int i = 0; i < DW; i++) begin
      unique case (sel_i)
        PN_SEL_9: fb = h[8] ^ h[4];
        PN_SEL_7: fb = h[6] ^ h[5];
        default:  fb = h[22] ^ h[17];
      endcase
      h = {h[HW-2:0], fb};
    end
    hist_adv = h;
  end

  assign expect_o = hist_adv[DW-1:0] ^ inv_mask;

  generate
    if (HW > DW) begin : g_wide
      assign hist_load = {hist_q[HW-DW-1:0], sample_i ^ inv_mask};
    end else begin : g_narrow
      assign hist_load = sample_i ^ inv_mask;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (valid_i) hist_q <= reseed_i ? hist_load : hist_adv;
  end

  AST_RESEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && reseed_i |=> hist_q[DW-1:0] == $past(sample_i ^ inv_mask))
    else $error("history not loaded from sample");  // R2
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hist_q))
    else $error("history moved without valid");  // R9

endmodule

// File: rtl/pn_sync_fsm.sv
module pn_sync_fsm #(
  parameter int LOCK_RUN = 16,
  parameter int LOSS_RUN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic mismatch_i,
  input  logic oos_clr_i,
  input  logic err_clr_i,
  output logic oos_o,
  output logic err_o
);

  localparam int RUN_MAX = (LOCK_RUN > LOSS_RUN) ? LOCK_RUN : LOSS_RUN;
  localparam int CW      = (RUN_MAX > 1) ? $clog2(RUN_MAX) : 1;

  logic          oos_q, oos_d, err_q, err_d;
  logic [CW-1:0] run_q, run_d;

  // one run counter serves both directions; it restarts on every state change
  always_comb begin
    oos_d = oos_q;
    err_d = err_q;
    run_d = run_q;
    if (oos_q) begin
      if (valid_i) begin
        if (!mismatch_i) begin
          if (run_q == CW'(LOCK_RUN - 1)) begin
            oos_d = 1'b0;
            run_d = '0;
          end else begin
            run_d = run_q + CW'(1);
          end
        end else begin
          run_d = '0;
        end
      end
      if (oos_clr_i) begin
        oos_d = 1'b0;
        run_d = '0;
      end
    end else begin
      if (err_clr_i) err_d = 1'b0;
      if (valid_i) begin
        if (mismatch_i) begin
          err_d = 1'b1;
          if (run_q == CW'(LOSS_RUN - 1)) begin
            oos_d = 1'b1;
            run_d = '0;
          end else begin
            run_d = run_q + CW'(1);
          end
        end else begin
          run_d = '0;
        end
      end
    end
    if (oos_d) err_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oos_q <= 1'b1;
      err_q <= 1'b0;
      run_q <= '0;
    end else begin
      oos_q <= oos_d;
      err_q <= err_d;
      run_q <= run_d;
    end
  end

  assign oos_o = oos_q;
  assign err_o = err_q;

  AST_ERR_OFF_OOS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oos_q |-> !err_q)
    else $error("error flag set while out of lock");  // R6
  AST_OOS_SET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oos_q) |-> $past(valid_i && mismatch_i))
    else $error("lock lost without mismatch");  // R4
  AST_OOS_CLR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oos_q) |-> $past((valid_i && !mismatch_i) || oos_clr_i))
    else $error("lock gained without match or clear");  // R3
  AST_ERR_SET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(valid_i && mismatch_i))
    else $error("error flag set without mismatch");  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !oos_clr_i && !err_clr_i |=> $stable(oos_q) && $stable(err_q))
    else $error("flags moved on idle cycle");  // R9

endmodule

// File: rtl/pn_sync_monitor.sv
module pn_sync_monitor
  import pn_mon_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int DW       = 16,
  parameter int LOCK_RUN = 16,
  parameter int LOSS_RUN = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        valid_i,
  input  logic [NCH*DW-1:0]     data_i,
  input  logic [PN_SEL_W*NCH-1:0] sel_i,
  input  logic [NCH-1:0]        oos_clr_i,
  input  logic [NCH-1:0]        err_clr_i,
  output logic [NCH-1:0]        oos_o,
  output logic [NCH-1:0]        err_o,
  output logic                  any_oos_o,
  output logic                  any_err_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pn_sel_e       ch_sel;
    logic [DW-1:0] ch_exp;
    logic          ch_mis;

    assign ch_sel = pn_sel_e'(sel_i[PN_SEL_W*c +: PN_SEL_W]);
    assign ch_mis = data_i[c*DW +: DW] != ch_exp;

    pn_gen #(.DW(DW)) u_gen (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_i[c]),
      .reseed_i (oos_o[c]),
      .sel_i    (ch_sel),
      .sample_i (data_i[c*DW +: DW]),
      .expect_o (ch_exp)
    );

    pn_sync_fsm #(.LOCK_RUN(LOCK_RUN), .LOSS_RUN(LOSS_RUN)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (valid_i[c]),
      .mismatch_i (ch_mis),
      .oos_clr_i  (oos_clr_i[c]),
      .err_clr_i  (err_clr_i[c]),
      .oos_o      (oos_o[c]),
      .err_o      (err_o[c])
    );
  end

  assign any_oos_o = |oos_o;
  assign any_err_o = |err_o;

endmodule

// File: tb/pn_sync_monitor_test.sv
`timescale 1ns/1ps
module pn_sync_monitor_test;

  localparam int NCH = 2;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic [NCH-1:0]    valid_i, oos_clr_i, err_clr_i, oos_o, err_o;
  logic [NCH*DW-1:0] data_i;
  logic [2*NCH-1:0]  sel_i;
  logic              any_oos_o, any_err_o;

  always #2.5 clk = ~clk;

  pn_sync_monitor #(.NCH(NCH), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i), .sel_i(sel_i),
    .oos_clr_i(oos_clr_i), .err_clr_i(err_clr_i), .oos_o(oos_o), .err_o(err_o),
    .any_oos_o(any_oos_o), .any_err_o(any_err_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // requirement model per channel
  bit          m_oos [NCH];
  bit          m_err [NCH];
  bit          m_prev[NCH];
  int          m_run [NCH];
  logic [31:0] st    [NCH];
  logic [1:0]  msel  [NCH];

  // scoreboard queue: {err, oos} expected after a given cycle
  int               q_cyc[$];
  logic [2*NCH-1:0] q_exp[$];
  string            q_tag[$];

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
      logic [2*NCH-1:0] e;
      string            t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      void'(q_cyc.pop_front());
      for (int c = 0; c < NCH; c++) begin
        check_bit(t, $sformatf("oos%0d", c), oos_o[c], e[c]);
        check_bit(t, $sformatf("err%0d", c), err_o[c], e[NCH+c]);
      end
      check_bit(t, "any_oos R10", any_oos_o, |e[NCH-1:0]);
      check_bit(t, "any_err R10", any_err_o, |e[2*NCH-1:NCH]);
    end
  end

  // serial sequence source, earliest bit to word MSB (R2)
  task automatic gen_word(input int ch, output logic [DW-1:0] w);
    logic b;
    w = '0;
    for (int j = 0; j < DW; j++) begin
      case (msel[ch])
        2'd0:    b = st[ch][8] ^ st[ch][4];
        2'd3:    b = st[ch][6] ^ st[ch][5];
        default: b = st[ch][22] ^ st[ch][17];
      endcase
      st[ch] = {st[ch][30:0], b};
      w      = {w[DW-2:0], b};
    end
    if (msel[ch] == 2'd2) w = ~w;
  endtask

  task automatic drive(input int ch, input bit v, input bit clean, input bit eclr,
                       input bit oclr, input string tag);
    logic [DW-1:0]    w;
    logic [2*NCH-1:0] e;
    bit               match;
    w = '0;
    if (v) begin
      gen_word(ch, w);
      if (!clean) w[0] = ~w[0];
    end
    valid_i[ch]           = v;
    data_i[ch*DW +: DW]   = w;
    err_clr_i[ch]         = eclr;
    oos_clr_i[ch]         = oclr;
    if (m_oos[ch]) begin
      if (v) begin
        match = clean && m_prev[ch];
        if (match) begin
          m_run[ch]++;
          if (m_run[ch] == 16) begin m_oos[ch] = 0; m_run[ch] = 0; end
        end else m_run[ch] = 0;
      end
      if (oclr) begin m_oos[ch] = 0; m_run[ch] = 0; end
    end else begin
      if (eclr) m_err[ch] = 0;
      if (v) begin
        if (!clean) begin
          m_err[ch] = 1;
          m_run[ch]++;
          if (m_run[ch] == 64) begin m_oos[ch] = 1; m_run[ch] = 0; end
        end else m_run[ch] = 0;
      end
    end
    if (m_oos[ch]) m_err[ch] = 0;
    if (v) m_prev[ch] = clean;
    for (int c = 0; c < NCH; c++) begin
      e[c]     = m_oos[c];
      e[NCH+c] = m_err[c];
    end
    q_cyc.push_back(cyc + 1);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    valid_i[ch]   = 1'b0;
    err_clr_i[ch] = 1'b0;
    oos_clr_i[ch] = 1'b0;
  endtask

  task automatic run_n(input int ch, input int n, input bit clean, input string tag);
    for (int i = 0; i < n; i++) drive(ch, 1, clean, 0, 0, tag);
  endtask

  task automatic do_reset(input logic [1:0] s1, input logic [31:0] seed1);
    rst_ni = 1'b0;
    msel[0] = 2'd0; st[0] = 32'h0000_01FF;
    msel[1] = s1;   st[1] = seed1;
    sel_i = {msel[1], msel[0]};
    for (int c = 0; c < NCH; c++) begin
      m_oos[c] = 1; m_err[c] = 0; m_prev[c] = 0; m_run[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    drive(0, 0, 1, 0, 0, "R1 reset state");
  endtask

  initial begin
    #250000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; valid_i = '0; oos_clr_i = '0; err_clr_i = '0; data_i = '0; sel_i = '0;
    @(negedge clk);
    do_reset(2'd3, 32'h0000_007F);

    // ch0, sequence code 0: word 1 misses, words 2..17 lock
    run_n(0, 17, 1, "R2/R3 lock 9-order");
    drive(0, 0, 1, 0, 0, "R9 idle");
    drive(0, 0, 1, 0, 0, "R9 idle");
    run_n(0, 3, 1, "R5 clean in lock");
    run_n(0, 1, 0, "R5 mismatch sets err");
    run_n(0, 2, 1, "R5 err sticky");
    drive(0, 0, 1, 1, 0, "R7 err clear");
    drive(0, 1, 0, 1, 0, "R7 set beats clear");
    run_n(0, 1, 1, "R4 match restarts run");
    run_n(0, 10, 0, "R4 mismatch run");
    drive(0, 0, 1, 0, 1, "R8 clear ignored in lock");
    run_n(0, 53, 0, "R4 mismatch run");
    run_n(0, 1, 0, "R4/R6 64th mismatch loses lock");
    run_n(0, 5, 0, "R6 no err while out of lock");
    run_n(0, 4, 1, "R3 partial relock");
    drive(0, 0, 1, 0, 1, "R8 forced lock");
    run_n(0, 5, 1, "R8 generator continues");

    // ch1, sequence code 3, mismatch restarts lock run
    run_n(1, 10, 1, "R3/R10 partial run");
    run_n(1, 1, 0, "R3 run broken");
    run_n(1, 16, 1, "R3 not yet locked");
    run_n(1, 1, 1, "R3/R10 locked");
    run_n(1, 1, 0, "R10 err aggregate");

    // 23-order sequences
    do_reset(2'd1, 32'h007F_FF80);
    run_n(1, 17, 1, "R2 lock 23-order");
    do_reset(2'd2, 32'h007F_FF80);
    run_n(1, 17, 1, "R2 lock 23-order inverted");

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule